// File: doc/BRIEF.md
# Flash Page Erase Sequencer

This block erases one page of a small on-chip memory array that models flash storage. The erase is started through three register writes. Software first sets an erase-enable bit. It then writes the absolute byte address of the target page. Last, it sets a start bit. The sequencer raises a busy flag and writes the all-ones word to every location of the chosen page, one word per clock. When the last word is written, busy falls and a sticky completion flag is set. If the completion interrupt is enabled, the interrupt line is raised.

Addresses are absolute and must fall inside a window that begins at 0x0800_0000 and spans the whole array. The page is selected by the address bits above the page-size boundary, so any byte offset within a page selects that page. An address outside the window erases nothing and sets an error flag instead of the completion flag. A read port on the array lets the surrounding logic observe its contents. Word `i` of the array holds `0x0BAD_0000 + i` after reset.

Top module: `flash_page_eraser`

## Requirements
- R1: After reset, CTRL (offset 0) and STAT (offset 2) read 0, `irq_o` is 0, and array word `i` reads `0x0BAD_0000 + i`.
- R2: An erase sets every word of the selected page to `0xFFFF_FFFF` and leaves every word of every other page unchanged.
- R3: The page erased is `(addr - 0x0800_0000) / (WORDS_PER_PAGE*4)`. Any byte offset inside a page selects the same page.
- R4: A start is dropped with no busy, no flags and no array change in either of two cases:
  - CTRL bit 0 (erase enable) is 0.
  - ADDR (offset 1) has not been written since the last accepted start.
- R5: Busy (STAT bit 0) goes to 1 on the clock edge after the edge that writes start (CTRL bit 1). It stays at 1 for exactly WORDS_PER_PAGE cycles.
- R6: The start bit reads 1 only until the operation begins. It reads 0 once busy is 1.
- R7: The end flag (STAT bit 1) is set on the edge where busy falls. It stays set until software writes 1 to STAT bit 1.
- R8: `irq_o` is 1 exactly when the end flag is 1 and the end-interrupt enable (CTRL bit 2) is 1.
- R9: A start with an address outside `[0x0800_0000, 0x0800_0000 + PAGES*WORDS_PER_PAGE*4)` sets the error flag (STAT bit 2) one edge later. It does not set busy or the end flag and erases nothing. Writing 1 to STAT bit 2 clears the error flag.
- R10: Writes to CTRL and ADDR while busy is 1 are ignored, and this includes a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset: 0 CTRL, 1 ADDR, 2 STAT |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_raddr_i | input | AW | Array word index for observation |
| mem_rdata_o | output | 32 | Array word at `mem_raddr_i` (combinational) |
| irq_o | output | 1 | Completion interrupt |

## Verification
A write takes effect at the first rising edge after it is presented. Busy and the self-clearing of start are due one edge later. The error flag for a bad address is also due one edge later. The end flag, the interrupt and the final array contents are due WORDS_PER_PAGE edges after busy rises. The bench drives on falling edges and samples the combinational read ports half a cycle later. It counts busy samples edge by edge to measure the erase length. It compares the whole array against an arithmetic model after each of the twelve erases of the page and offset sweep.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [31:0] FLASH_BASE = 32'h0800_0000;
  localparam logic [31:0] INIT_BASE  = 32'h0BAD_0000;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  // control and status bit positions
  localparam int unsigned C_EN = 0, C_START = 1, C_IE = 2;
  localparam int unsigned S_BUSY = 0, S_END = 1, S_ERR = 2;
endpackage

// File: rtl/fpe_decode.sv
module fpe_decode #(
  parameter int unsigned PAGES = 4,
  parameter int unsigned WORDS_PER_PAGE = 8,
  localparam int unsigned PG_W = $clog2(PAGES),
  localparam int unsigned PB_W = $clog2(WORDS_PER_PAGE * 4)
) (
  input  logic [31:0]     addr_i,
  output logic            in_win_o,
  output logic [PG_W-1:0] page_o
);
  import fpe_pkg::*;
  localparam logic [31:0] FLASH_BYTES = 32'(PAGES * WORDS_PER_PAGE * 4);

  logic [31:0] off;
  assign off      = addr_i - FLASH_BASE;
  assign in_win_o = (addr_i >= FLASH_BASE) && (off < FLASH_BYTES);
  assign page_o   = off[PB_W +: PG_W];
endmodule

// File: rtl/fpe_regs.sv
module fpe_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic        in_win_i,
  output logic [31:0] rdata_o,
  output logic [31:0] page_addr_o,
  output logic        launch_o,
  output logic        start_o,
  output logic        end_o,
  output logic        err_o,
  output logic        ie_o
);
  import fpe_pkg::*;

  logic en_q, ie_q, start_q, addr_ld_q, end_q, err_q;
  logic [31:0] addr_q;
  logic ctrl_wr, addr_wr, stat_wr, go;

  assign ctrl_wr  = we_i && addr_i == REG_CTRL && !busy_i;
  assign addr_wr  = we_i && addr_i == REG_ADDR && !busy_i;
  assign stat_wr  = we_i && addr_i == REG_STAT;
  assign go       = start_q && en_q && addr_ld_q;
  assign launch_o = go && in_win_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ie_q <= 1'b0; start_q <= 1'b0;
      addr_ld_q <= 1'b0; addr_q <= '0;
      end_q <= 1'b0; err_q <= 1'b0;
    end else begin
      start_q <= ctrl_wr && wdata_i[C_START];
      if (ctrl_wr) begin
        en_q <= wdata_i[C_EN];
        ie_q <= wdata_i[C_IE];
      end
      if (addr_wr) begin
        addr_q    <= wdata_i;
        addr_ld_q <= 1'b1;
      end else if (go) begin
        addr_ld_q <= 1'b0;
      end
      // set wins over write-one-to-clear
      if (done_i) end_q <= 1'b1;
      else if (stat_wr && wdata_i[S_END]) end_q <= 1'b0;
      if (go && !in_win_i) err_q <= 1'b1;
      else if (stat_wr && wdata_i[S_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[C_EN] = en_q; rdata_o[C_START] = start_q; rdata_o[C_IE] = ie_q;
      end
      REG_ADDR: rdata_o = addr_q;
      REG_STAT: begin
        rdata_o[S_BUSY] = busy_i; rdata_o[S_END] = end_q; rdata_o[S_ERR] = err_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign page_addr_o = addr_q;
  assign start_o     = start_q;
  assign end_o       = end_q;
  assign err_o       = err_q;
  assign ie_o        = ie_q;
endmodule

// File: rtl/fpe_seq.sv
module fpe_seq #(
  parameter int unsigned PAGES = 4,
  parameter int unsigned WORDS_PER_PAGE = 8,
  localparam int unsigned PG_W = $clog2(PAGES),
  localparam int unsigned WD_W = $clog2(WORDS_PER_PAGE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 launch_i,
  input  logic [PG_W-1:0]      page_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 we_o,
  output logic [PG_W+WD_W-1:0] waddr_o
);
  localparam logic [WD_W-1:0] LAST = WD_W'(WORDS_PER_PAGE - 1);

  logic            busy_q;
  logic [WD_W-1:0] cnt_q;
  logic [PG_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= '0; page_q <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      page_q <= page_i;
    end
  end

  assign busy_o  = busy_q;
  assign we_o    = busy_q;
  assign done_o  = busy_q && cnt_q == LAST;
  assign waddr_o = {page_q, cnt_q};
endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  import fpe_pkg::*;
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_BASE + 32'(i);
    end else if (we_i) begin
      mem_q[waddr_i] <= '1;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_page_eraser.sv
module flash_page_eraser #(
  parameter int unsigned PAGES = 4,
  parameter int unsigned WORDS_PER_PAGE = 8,
  localparam int unsigned DEPTH = PAGES * WORDS_PER_PAGE,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PG_W = $clog2(PAGES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [AW-1:0] mem_raddr_i,
  output logic [31:0]   mem_rdata_o,
  output logic          irq_o
);
  logic busy_w, done_w, in_win_w, launch_w, start_w, end_w, err_w, ie_w, mem_we_w;
  logic [31:0]     addr_w;
  logic [PG_W-1:0] page_w;
  logic [AW-1:0]   waddr_w;

  fpe_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy_w), .done_i(done_w), .in_win_i(in_win_w), .rdata_o(reg_rdata_o),
    .page_addr_o(addr_w), .launch_o(launch_w), .start_o(start_w),
    .end_o(end_w), .err_o(err_w), .ie_o(ie_w)
  );

  fpe_decode #(.PAGES(PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE)) u_dec (
    .addr_i(addr_w), .in_win_o(in_win_w), .page_o(page_w)
  );

  fpe_seq #(.PAGES(PAGES), .WORDS_PER_PAGE(WORDS_PER_PAGE)) u_seq (
    .clk_i, .rst_ni, .launch_i(launch_w), .page_i(page_w),
    .busy_o(busy_w), .done_o(done_w), .we_o(mem_we_w), .waddr_o(waddr_w)
  );

  fpe_array #(.DEPTH(DEPTH)) u_arr (
    .clk_i, .rst_ni, .we_i(mem_we_w), .waddr_i(waddr_w),
    .raddr_i(mem_raddr_i), .rdata_o(mem_rdata_o)
  );

  assign irq_o = end_w && ie_w;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int unsigned WORDS_PER_PAGE = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        start_i,
  input logic        end_i,
  input logic        err_i,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic [31:0] addr_i
);
  logic [31:0] run_q;
  logic        prev_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0; prev_busy_q <= 1'b0;
    end else begin
      prev_busy_q <= busy_i;
      run_q <= busy_i ? run_q + 1 : '0;
    end
  end

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_busy_q && !busy_i) |-> run_q == 32'(WORDS_PER_PAGE));
  // R7
  end_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_busy_q && !busy_i) |-> end_i);
  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !prev_busy_q) |-> !start_i);
  // R9
  err_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> !busy_i);
  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_we_i && reg_addr_i == 2'd1) |=> $stable(addr_i));
endmodule

bind flash_page_eraser fpe_checker #(.WORDS_PER_PAGE(WORDS_PER_PAGE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_w), .start_i(start_w),
  .end_i(end_w), .err_i(err_w), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .addr_i(addr_w)
);

// File: tb/flash_page_eraser_tb_top.sv
module flash_page_eraser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAGES = 4;
  localparam int WPP = 8;
  localparam int DEPTH = PAGES * WPP;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam logic [31:0] INIT = 32'h0BAD_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] ra = '0;
  logic [31:0] wd = '0, rd, md;
  logic [AW-1:0] maddr = '0;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_eraser #(.PAGES(PAGES), .WORDS_PER_PAGE(WPP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .mem_raddr_i(maddr), .mem_rdata_o(md), .irq_o(irq)
  );

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
    ra = a; #1; v = rd;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = INIT + 32'(i);
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      maddr = AW'(i); #1;
      if (md !== exp_mem[i]) begin
        bad++;
        $display("FAIL %s word %0d actual=%h expected=%h", req, i, md, exp_mem[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  // start already written; call at the negedge after the start edge
  task automatic run_erase(input int page, input logic ie);
    logic [31:0] v;
    int n = 0;
    @(negedge clk);
    rdreg(2'd0, v); chk("R6 start self-clear", 32'(v[1]), 0);
    rdreg(2'd2, v); chk("R5 busy after one edge", 32'(v[0]), 1);
    while (n < 100) begin
      rdreg(2'd2, v);
      if (!v[0]) break;
      n++;
      @(negedge clk);
    end
    chk("R5 busy length", 32'(n), 32'(WPP));
    rdreg(2'd2, v); chk("R7 end set", 32'(v[1]), 1);
    chk("R8 irq", 32'(irq), 32'(ie));
    for (int w = 0; w < WPP; w++) exp_mem[page*WPP + w] = '1;
  endtask

  initial begin
    logic [31:0] v;
    int offs [3] = '{0, 13, 31};
    // R1 reset state
    #(CLK_PERIOD*2 + 2);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = INIT + 32'(i);
    rdreg(2'd0, v); chk("R1 ctrl reset", v, 0);
    rdreg(2'd2, v); chk("R1 stat reset", v, 0);
    chk("R1 irq reset", 32'(irq), 0);
    chk_mem("R1 array init");

    // R2 R3 sweep pages and offsets
    for (int p = 0; p < PAGES; p++) begin
      for (int o = 0; o < 3; o++) begin
        logic ie = logic'((p + o) % 2);
        do_reset();
        wr(2'd1, BASE + 32'(p*WPP*4 + offs[o]));
        wr(2'd0, {29'd0, ie, 1'b0, 1'b1});
        wr(2'd0, {29'd0, ie, 1'b1, 1'b1});
        run_erase(p, ie);
        chk_mem("R2 R3 page erase");
      end
    end

    // R7 R8 end flag sticky and cleared by writing one
    do_reset();
    wr(2'd1, BASE + 32'(2*WPP*4));
    wr(2'd0, 32'h5);
    wr(2'd0, 32'h7);
    run_erase(2, 1'b1);
    repeat (3) @(negedge clk);
    rdreg(2'd2, v); chk("R7 end sticky", 32'(v[1]), 1);
    wr(2'd2, 32'h4);
    rdreg(2'd2, v); chk("R7 wrong bit keeps end", 32'(v[1]), 1);
    wr(2'd2, 32'h2);
    rdreg(2'd2, v); chk("R7 end cleared", v, 0);
    chk("R8 irq follows end", 32'(irq), 0);

    // R4 no erase enable
    do_reset();
    wr(2'd1, BASE);
    wr(2'd0, 32'h2);
    repeat (2) @(negedge clk);
    rdreg(2'd2, v); chk("R4 no enable no effect", v, 0);
    rdreg(2'd0, v); chk("R4 start reads 0", 32'(v[1]), 0);
    chk_mem("R4 array untouched no enable");
    // R4 address not rewritten since last launch
    wr(2'd0, 32'h3);
    run_erase(0, 1'b0);
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h3);
    repeat (2) @(negedge clk);
    rdreg(2'd2, v); chk("R4 stale address no effect", v, 0);
    chk_mem("R4 array after stale start");

    // R10 writes during busy ignored
    do_reset();
    wr(2'd1, BASE + 32'(WPP*4));
    wr(2'd0, 32'h3);
    @(negedge clk);                         // busy now
    we = 1'b1; ra = 2'd1; wd = BASE + 32'(3*WPP*4);
    @(negedge clk); ra = 2'd0; wd = 32'h7;
    @(negedge clk); we = 1'b0;
    repeat (WPP + 4) @(negedge clk);
    rdreg(2'd1, v); chk("R10 addr unchanged", v, BASE + 32'(WPP*4));
    rdreg(2'd0, v); chk("R10 ctrl unchanged", v, 32'h1);
    rdreg(2'd2, v); chk("R10 single completion", v, 32'h2);
    for (int w = 0; w < WPP; w++) exp_mem[WPP + w] = '1;
    chk_mem("R10 only first page erased");

    // R9 out of window, below and above
    for (int k = 0; k < 2; k++) begin
      do_reset();
      wr(2'd1, k == 0 ? BASE - 32'd4 : BASE + 32'(DEPTH*4));
      wr(2'd0, 32'h7);
      @(negedge clk);
      rdreg(2'd2, v); chk("R9 error flag only", v, 32'h4);
      chk("R9 no irq", 32'(irq), 0);
      chk_mem("R9 nothing erased");
      wr(2'd2, 32'h4);
      rdreg(2'd2, v); chk("R9 error cleared", v, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule